// File: doc/BRIEF.md
# Handshaked Parallel Port Buffer

This block sits between an 8-bit CPU data bus and a 16-bit external parallel port. The CPU sees three byte-wide registers: one per port byte lane and one control register. A single handshake pair serves every transfer: a port-enable output (`pe`) and an active-low strobe input (`ar_n`), whose falling edge ends the transfer. No bit selects direction. The same sequence carries data in and data out, and the external logic must know which one is in progress.

For input, the CPU clears the ready bit, and that raises `pe`. The external logic pulls selected pins low and then strobes `ar_n` low. On that edge the block captures the pin levels, lowers `pe`, sets ready again and, if interrupts are enabled, asserts `irq_n`. For output, a CPU write to a data lane raises `pe`. In two-byte-port mode one lane write is enough. In word mode both lanes must be written. An acknowledge pulse on `iack` releases the interrupt request. Only the strobe edge matters, so the strobe may rest low and be pulsed high briefly.

Pins follow a drive-low scheme. A lane drives low only the bits written as 0 and releases the rest, which are pulled high.

Top module: `pario_bridge`

## Requirements
- R1: After reset: `pe`=0, `irq_n`=1, `pin_out`=16'hFFFF, `pin_oe`=0. The control register reads 8'h01 and both data lanes read 8'hFF.
- R2: Register map: address 0 is the low lane (pins 7:0), address 1 is the high lane (pins 15:8) and address 2 is control. Control bit 0 is ready, bit 1 is interrupt enable and bit 2 selects word mode (1) or two-byte-port mode (0). A control read returns these bits with bits 7:3 as 0. `bus_rdata` updates at the clock edge that samples `bus_sel`&`bus_rd`.
- R3: A control write with bit 0 = 0 sets `pe` at the next edge, and ready then reads 0.
- R4: A falling edge of `ar_n`, passed through a two-stage synchronizer, lowers `pe` at the third clock edge after `ar_n` goes low. On the same edge the block sets ready to 1 and captures `pin_in` into the lane read values. Holding `ar_n` low has no further effect. A high pulse of one cycle followed by a return low is a new edge.
- R5: On that edge, `irq_n` goes low if interrupt enable is 1. It stays high if interrupt enable is 0.
- R6: A rising edge of `iack`, synchronized the same way, sets `irq_n` high at the third clock edge after `iack` rises.
- R7: In two-byte-port mode, a write to either lane sets `pe` at the next edge.
- R8: In word mode, `pe` stays low after a write to only one lane. It rises at the edge of the write that completes the pair, in either order.
- R9: Partial pair progress is discarded when a handshake completes (`ar_n` edge) or when a control write changes the mode bit. The next single lane write then leaves `pe` low.
- R10: A lane write sets that lane of `pin_out` to the written byte at the next edge. At all times `pin_oe` equals the bitwise inverse of `pin_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Block selected for this cycle |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Registered read data byte |
| ar_n | input | 1 | Active-low transfer strobe, asynchronous |
| iack | input | 1 | Interrupt acknowledge pulse, asynchronous |
| pe | output | 1 | Port enable / transfer pending |
| irq_n | output | 1 | Active-low interrupt request |
| pin_in | input | 16 | Sensed pin levels |
| pin_out | output | 16 | Pin output values |
| pin_oe | output | 16 | Per-pin drive enable (drive low) |

## Verification
Faults in the synchronizer or edge detector show up as `pe` or `irq_n` changing one cycle early or late relative to the three-edge latency. A detector that responds to level instead of edge shows up as a missed or repeated handshake while `ar_n` rests low. Stale or uncleared pair-tracking flags appear at `pe` on the very next lane write in word mode, as a rise that is premature or missing. A wrong control or capture register shows up in the next read, one cycle after the read strobe. The per-cycle reference comparison catches these faults in the cycle where they first reach a port.

// File: rtl/pario_pkg.sv
package pario_pkg;
  localparam int BIT_READY = 0;
  localparam int BIT_IE    = 1;
  localparam int BIT_WIDE  = 2;

  typedef struct packed {
    logic wide;
    logic ie;
    logic ready;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{wide: 1'b0, ie: 1'b0, ready: 1'b1};
endpackage

// File: rtl/pario_sync.sv
module pario_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic fall_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= {STAGES{RST_VAL}};
      prev_q  <= RST_VAL;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign fall_o = prev_q & ~chain_q[STAGES-1];
  assign rise_o = ~prev_q & chain_q[STAGES-1];
endmodule

// File: rtl/pario_regs.sv
module pario_regs
  import pario_pkg::*;
#(
  parameter int DW    = 8,
  parameter int LANES = 2,
  parameter int AW    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sel,
  input  logic                wr,
  input  logic                rd,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       wdata,
  input  logic [DW*LANES-1:0] pin_in,
  input  logic                ar_fall,
  output logic [DW-1:0]       rdata,
  output logic [DW*LANES-1:0] pin_out,
  output logic [DW*LANES-1:0] pin_oe,
  output logic [LANES-1:0]    lane_wr,
  output logic                ready_clr,
  output logic                mode_chg,
  output logic                ie,
  output logic                wide
);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(LANES);

  ctrl_t               ctrl_q;
  logic [DW*LANES-1:0] inlat_q;
  logic [DW*LANES-1:0] out_q;
  logic [DW*LANES-1:0] oe_q;
  logic [DW-1:0]       rd_mux;
  logic [DW-1:0]       rdata_q;
  logic                ctrl_wr;

  assign ctrl_wr   = sel & wr & (addr == CTRL_ADDR);
  assign ready_clr = ctrl_wr & ~wdata[BIT_READY];
  assign mode_chg  = ctrl_wr & (wdata[BIT_WIDE] != ctrl_q.wide);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RESET;
    end else if (ctrl_wr) begin
      ctrl_q.wide  <= wdata[BIT_WIDE];
      ctrl_q.ie    <= wdata[BIT_IE];
      ctrl_q.ready <= wdata[BIT_READY];
    end else if (ar_fall) begin
      ctrl_q.ready <= 1'b1;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_wr[g] = sel & wr & (addr == AW'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        out_q[g*DW +: DW] <= '1;
        oe_q[g*DW +: DW]  <= '0;
      end else if (lane_wr[g]) begin
        out_q[g*DW +: DW] <= wdata;
        oe_q[g*DW +: DW]  <= ~wdata;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        inlat_q[g*DW +: DW] <= '1;
      end else if (ar_fall) begin
        inlat_q[g*DW +: DW] <= pin_in[g*DW +: DW];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < LANES; i++) begin
      if (addr == AW'(i)) rd_mux = inlat_q[i*DW +: DW];
    end
    if (addr == CTRL_ADDR) begin
      rd_mux[BIT_READY] = ctrl_q.ready;
      rd_mux[BIT_IE]    = ctrl_q.ie;
      rd_mux[BIT_WIDE]  = ctrl_q.wide;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (sel & rd) rdata_q <= rd_mux;
  end

  assign rdata   = rdata_q;
  assign pin_out = out_q;
  assign pin_oe  = oe_q;
  assign ie      = ctrl_q.ie;
  assign wide    = ctrl_q.wide;
endmodule

// File: rtl/pario_hshake.sv
module pario_hshake #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ar_fall,
  input  logic             ack_rise,
  input  logic             ready_clr,
  input  logic [LANES-1:0] lane_wr,
  input  logic             wide,
  input  logic             mode_chg,
  input  logic             ie,
  output logic             pe,
  output logic             irq_n
);
  logic [LANES-1:0] seen_q;
  logic [LANES-1:0] seen_any;
  logic             pair_done;
  logic             pe_set;
  logic             pe_q;
  logic             irq_n_q;

  assign seen_any  = seen_q | lane_wr;
  assign pair_done = wide & (|lane_wr) & (&seen_any);
  assign pe_set    = ready_clr | (~wide & (|lane_wr)) | pair_done;

  always_ff @(posedge clk) begin
    if (rst) seen_q <= '0;
    else if (ar_fall | mode_chg | pair_done) seen_q <= '0;
    else seen_q <= seen_any;
  end

  always_ff @(posedge clk) begin
    if (rst) pe_q <= 1'b0;
    else if (pe_set) pe_q <= 1'b1;
    else if (ar_fall) pe_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_n_q <= 1'b1;
    else if (ar_fall & ie) irq_n_q <= 1'b0;
    else if (ack_rise) irq_n_q <= 1'b1;
  end

  assign pe    = pe_q;
  assign irq_n = irq_n_q;
endmodule

// File: rtl/pario_bridge.sv
module pario_bridge #(
  parameter int DW          = 8,
  parameter int LANES       = 2,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(LANES + 1),
  localparam int PW         = DW * LANES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          ar_n,
  input  logic          iack,
  output logic          pe,
  output logic          irq_n,
  input  logic [PW-1:0] pin_in,
  output logic [PW-1:0] pin_out,
  output logic [PW-1:0] pin_oe
);
  logic             ar_fall;
  logic             ar_rise_unused;
  logic             ack_rise;
  logic             ack_fall_unused;
  logic [LANES-1:0] lane_wr;
  logic             ready_clr;
  logic             mode_chg;
  logic             ctrl_ie;
  logic             ctrl_wide;

  pario_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ar_sync (
    .clk(clk), .rst(rst), .async_i(ar_n),
    .fall_o(ar_fall), .rise_o(ar_rise_unused)
  );

  pario_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ack_sync (
    .clk(clk), .rst(rst), .async_i(iack),
    .fall_o(ack_fall_unused), .rise_o(ack_rise)
  );

  pario_regs #(.DW(DW), .LANES(LANES), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .sel(bus_sel), .wr(bus_wr), .rd(bus_rd),
    .addr(bus_addr), .wdata(bus_wdata), .pin_in(pin_in), .ar_fall(ar_fall),
    .rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe),
    .lane_wr(lane_wr), .ready_clr(ready_clr), .mode_chg(mode_chg),
    .ie(ctrl_ie), .wide(ctrl_wide)
  );

  pario_hshake #(.LANES(LANES)) u_hshake (
    .clk(clk), .rst(rst), .ar_fall(ar_fall), .ack_rise(ack_rise),
    .ready_clr(ready_clr), .lane_wr(lane_wr), .wide(ctrl_wide),
    .mode_chg(mode_chg), .ie(ctrl_ie), .pe(pe), .irq_n(irq_n)
  );
endmodule

// File: rtl/pario_chk.sv
module pario_chk #(
  parameter int DW    = 8,
  parameter int LANES = 2,
  parameter int AW    = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_sel,
  input logic                bus_wr,
  input logic [AW-1:0]       bus_addr,
  input logic [DW-1:0]       bus_wdata,
  input logic                pe,
  input logic                irq_n,
  input logic [DW*LANES-1:0] pin_out,
  input logic [DW*LANES-1:0] pin_oe,
  input logic                ar_fall,
  input logic                ack_rise,
  input logic                ctrl_ie,
  input logic                ctrl_wide
);
  logic cw;
  logic lw;
  assign cw = bus_sel && bus_wr && (bus_addr == AW'(LANES));
  assign lw = bus_sel && bus_wr && (bus_addr < AW'(LANES));

  a_r3_ready_clear_raises_pe: assert property (@(posedge clk) disable iff (rst)
    (cw && !bus_wdata[0]) |=> pe);

  a_r4_edge_drops_pe: assert property (@(posedge clk) disable iff (rst)
    (ar_fall && !(bus_sel && bus_wr)) |=> !pe);

  a_r5_irq_on_edge: assert property (@(posedge clk) disable iff (rst)
    (ar_fall && ctrl_ie) |=> !irq_n);

  a_r5_irq_only_on_edge: assert property (@(posedge clk) disable iff (rst)
    (irq_n && !ar_fall) |=> irq_n);

  a_r6_ack_releases: assert property (@(posedge clk) disable iff (rst)
    (ack_rise && !ar_fall) |=> irq_n);

  a_r7_narrow_write_raises_pe: assert property (@(posedge clk) disable iff (rst)
    (lw && !ctrl_wide) |=> pe);

  a_r10_oe_inverse: assert property (@(posedge clk) disable iff (rst)
    pin_oe == ~pin_out);
endmodule

bind pario_bridge pario_chk #(.DW(DW), .LANES(LANES), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pe(pe), .irq_n(irq_n),
  .pin_out(pin_out), .pin_oe(pin_oe), .ar_fall(ar_fall),
  .ack_rise(ack_rise), .ctrl_ie(ctrl_ie), .ctrl_wide(ctrl_wide)
);

// File: tb/tb_pario_bridge.sv
module tb_pario_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [7:0]  bus_wdata = 8'd0;
  logic [7:0]  bus_rdata;
  logic        ar_n = 1'b1, iack = 1'b0;
  logic        pe, irq_n;
  logic [15:0] pin_in = 16'hFFFF;
  logic [15:0] pin_out, pin_oe;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  pario_bridge dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ar_n(ar_n), .iack(iack), .pe(pe), .irq_n(irq_n),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model, advanced on every rising edge
  logic        m_pe, m_irqn, m_rdy, m_ie, m_wide, m_lo, m_hi;
  logic [15:0] m_out, m_lat;
  logic [7:0]  m_rd;
  logic [2:0]  m_ar, m_ak;
  always @(posedge clk) begin
    logic f, r, cw, l0, l1, done, setp;
    if (rst) begin
      m_pe = 0; m_irqn = 1; m_rdy = 1; m_ie = 0; m_wide = 0; m_lo = 0; m_hi = 0;
      m_out = 16'hFFFF; m_lat = 16'hFFFF; m_rd = 0; m_ar = 3'b111; m_ak = 3'b000;
    end else begin
      f  = m_ar[2] & ~m_ar[1];
      r  = ~m_ak[2] & m_ak[1];
      m_ar = {m_ar[1:0], ar_n};
      m_ak = {m_ak[1:0], iack};
      cw = bus_sel && bus_wr && bus_addr == 2'd2;
      l0 = bus_sel && bus_wr && bus_addr == 2'd0;
      l1 = bus_sel && bus_wr && bus_addr == 2'd1;
      if (bus_sel && bus_rd)
        m_rd = (bus_addr == 2'd0) ? m_lat[7:0] : (bus_addr == 2'd1) ? m_lat[15:8] :
               (bus_addr == 2'd2) ? {5'b0, m_wide, m_ie, m_rdy} : 8'h00;
      done = m_wide && (l0 || l1) && (l0 || m_lo) && (l1 || m_hi);
      setp = (cw && !bus_wdata[0]) || (!m_wide && (l0 || l1)) || done;
      if (setp) m_pe = 1; else if (f) m_pe = 0;
      if (f && m_ie) m_irqn = 0; else if (r) m_irqn = 1;
      if (f || done || (cw && bus_wdata[2] != m_wide)) begin m_lo = 0; m_hi = 0; end
      else begin m_lo = m_lo | l0; m_hi = m_hi | l1; end
      if (f) m_lat = pin_in;
      if (cw) {m_wide, m_ie, m_rdy} = bus_wdata[2:0]; else if (f) m_rdy = 1;
      if (l0) m_out[7:0] = bus_wdata;
      if (l1) m_out[15:8] = bus_wdata;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R3 pe vs model", {31'd0, pe}, {31'd0, m_pe});
      chk("R5 irq_n vs model", {31'd0, irq_n}, {31'd0, m_irqn});
      chk("R10 pin_out vs model", {16'd0, pin_out}, {16'd0, m_out});
      chk("R2 rdata vs model", {24'd0, bus_rdata}, {24'd0, m_rd});
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bwr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic brd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_sel = 0; bus_rd = 0; d = bus_rdata;
  endtask

  task automatic ar_pulse;
    @(negedge clk); ar_n = 1;
    @(negedge clk); ar_n = 0;
    cyc(4);
  endtask

  task automatic ack_pulse;
    @(negedge clk); iack = 1;
    @(negedge clk); iack = 0;
    cyc(4);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    cyc(4);
    rst = 0;
    cyc(1);
    // R1 reset state
    chk("R1 pe", {31'd0, pe}, 32'd0);
    chk("R1 irq_n", {31'd0, irq_n}, 32'd1);
    chk("R1 pin_out", {16'd0, pin_out}, 32'hFFFF);
    chk("R1 pin_oe", {16'd0, pin_oe}, 32'h0);
    brd(2'd2, d); chk("R1 ctrl", {24'd0, d}, 32'h01);
    brd(2'd0, d); chk("R1 lane0", {24'd0, d}, 32'hFF);
    brd(2'd1, d); chk("R1 lane1", {24'd0, d}, 32'hFF);
    // R2 control bits and zero upper bits
    bwr(2'd2, 8'hFF); brd(2'd2, d); chk("R2 ctrl upper zero", {24'd0, d}, 32'h07);
    bwr(2'd2, 8'h03); brd(2'd2, d); chk("R2 ctrl readback", {24'd0, d}, 32'h03);
    chk("R2 pe untouched", {31'd0, pe}, 32'd0);
    // R3 clear ready raises pe
    pin_in = 16'hA55A;
    bwr(2'd2, 8'h02);
    chk("R3 pe raised", {31'd0, pe}, 32'd1);
    brd(2'd2, d); chk("R3 ready reads 0", {24'd0, d}, 32'h02);
    // R4 edge latency
    @(negedge clk); ar_n = 0;
    cyc(2); chk("R4 pe before sync", {31'd0, pe}, 32'd1);
    cyc(1); chk("R4 pe dropped on third edge", {31'd0, pe}, 32'd0);
    chk("R5 irq asserted", {31'd0, irq_n}, 32'd0);
    brd(2'd2, d); chk("R4 ready set", {24'd0, d}, 32'h03);
    brd(2'd0, d); chk("R4 capture low", {24'd0, d}, 32'h5A);
    brd(2'd1, d); chk("R4 capture high", {24'd0, d}, 32'hA5);
    // R6 ack latency
    @(negedge clk); iack = 1;
    @(negedge clk); iack = 0;
    cyc(1); chk("R6 irq held before sync", {31'd0, irq_n}, 32'd0);
    cyc(1); chk("R6 irq released", {31'd0, irq_n}, 32'd1);
    // R4 level held low has no effect; short high pulse is a new edge
    bwr(2'd2, 8'h02);
    cyc(6); chk("R4 low level ignored", {31'd0, pe}, 32'd1);
    pin_in = 16'h0F0F;
    ar_pulse;
    chk("R4 pulse completes", {31'd0, pe}, 32'd0);
    chk("R5 irq on pulse", {31'd0, irq_n}, 32'd0);
    ack_pulse;
    // R5 no irq when disabled
    bwr(2'd2, 8'h00);
    chk("R3 pe raised ie off", {31'd0, pe}, 32'd1);
    ar_pulse;
    chk("R5 pe dropped ie off", {31'd0, pe}, 32'd0);
    chk("R5 no irq ie off", {31'd0, irq_n}, 32'd1);
    // R7 narrow mode lane writes
    bwr(2'd2, 8'h03);
    bwr(2'd1, 8'h3C);
    chk("R7 high lane raises pe", {31'd0, pe}, 32'd1);
    chk("R10 pin_out high lane", {16'd0, pin_out}, 32'h3CFF);
    chk("R10 pin_oe inverse", {16'd0, pin_oe}, 32'hC300);
    ar_pulse; ack_pulse;
    bwr(2'd0, 8'h81);
    chk("R7 low lane raises pe", {31'd0, pe}, 32'd1);
    chk("R10 pin_out low lane", {16'd0, pin_out}, 32'h3C81);
    ar_pulse; ack_pulse;
    // R8 word mode pairing
    bwr(2'd2, 8'h05);
    bwr(2'd0, 8'h12); cyc(2);
    chk("R8 one lane keeps pe low", {31'd0, pe}, 32'd0);
    bwr(2'd1, 8'h34);
    chk("R8 pair raises pe", {31'd0, pe}, 32'd1);
    chk("R10 word out", {16'd0, pin_out}, 32'h3412);
    ar_pulse;
    bwr(2'd1, 8'h56);
    chk("R8 reverse first", {31'd0, pe}, 32'd0);
    bwr(2'd0, 8'h78);
    chk("R8 reverse pair", {31'd0, pe}, 32'd1);
    ar_pulse;
    // R9 flags cleared by handshake
    bwr(2'd0, 8'h11);
    ar_pulse;
    bwr(2'd1, 8'h22);
    chk("R9 handshake cleared pair", {31'd0, pe}, 32'd0);
    bwr(2'd0, 8'h33);
    chk("R9 new pair completes", {31'd0, pe}, 32'd1);
    ar_pulse;
    // R9 flags cleared by mode change
    bwr(2'd0, 8'h44);
    bwr(2'd2, 8'h01);
    bwr(2'd2, 8'h05);
    bwr(2'd1, 8'h55);
    chk("R9 mode change cleared pair", {31'd0, pe}, 32'd0);
    cyc(3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule